// File: doc/BRIEF.md
# Lookup Table Output Stage with Saturation Override

This block is the last stage of a pixel or sample datapath. Each cycle an upstream stage may present an 8-bit index together with two overflow flags, one for overflow past the top of the range and one for overflow past the bottom. With no overflow the block returns the indexed entry of a 256-byte lookup table. When an overflow flag is set it returns one of two programmable 32-bit saturation words instead. The result appears one clock later, with a valid bit that follows the input valid.

A narrow output mode returns a single table byte, zero-extended to 32 bits. A wide mode treats the table as 64 little-endian 32-bit words.

A host loads and reads the table and both saturation words over a byte-wide bus with a 9-bit address. The host may only do so while the run-control input is low. While the datapath runs, host writes are dropped and host reads return zero.

Top module: `lut_sat_stage`

## Requirements
- R1: While reset is asserted and right after it is released, `outValid` is 0 and `outData` and `hostRdData` are 0.
- R2: With `runEn` = 0, a host write to address 0x100+n stores the byte in table entry n. A host read of that address returns the byte on `hostRdData` one clock after the read strobe.
- R3: The upper saturation word occupies host addresses 0x0F8–0x0FB and the lower saturation word occupies 0x0FC–0x0FF. In both words the least significant byte sits at the lowest address, and each byte reads back as written.
- R4: In narrow mode (`mode32` = 0) with no overflow, `outData` one clock after `idxValid` equals table entry `idx` with bits 31:8 zero. `outValid` equals `idxValid` delayed by one clock.
- R5: In wide mode (`mode32` = 1) with no overflow, the output is word w = idx[7:2]. That word is {entry 4w+3, entry 4w+2, entry 4w+1, entry 4w}, so the entry at the lowest address is the least significant byte.
- R6: When `posOvf` = 1, the output is the upper saturation word. In narrow mode only its low byte is used, zero-extended.
- R7: When `negOvf` = 1 and `posOvf` = 0, the output is the lower saturation word. In narrow mode only its low byte is used, zero-extended.
- R8: When `posOvf` and `negOvf` are both 1 in the same cycle, the upper saturation word wins.
- R9: While `runEn` = 1, host writes change neither the table nor the saturation words.
- R10: While `runEn` = 1, every host read returns 0.
- R11: Host reads of addresses below 0x0F8 return 0. Host writes to those addresses change no table entry or saturation word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run control; 1 locks out host access |
| mode32 | input | 1 | 1 selects the 32-bit word output view |
| idxValid | input | 1 | Index and flags are valid this cycle |
| idx | input | 8 | Table index |
| posOvf | input | 1 | Overflow past the upper limit |
| negOvf | input | 1 | Overflow past the lower limit |
| hostAddr | input | 9 | Host byte address |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, one clock after the strobe |
| outValid | output | 1 | Output data valid |
| outData | output | 32 | Output word |

## Verification
The embedded properties check several things on every cycle: the one-clock relation between `idxValid` and `outValid`, which saturation word wins for each flag combination in wide mode, the zero upper bytes in narrow mode, and zero read data while running or at unmapped addresses. Only the bench scenarios can show that table contents and the wide-word byte order are right, since those need known loaded data. The same holds for the claim that writes attempted while running or to unmapped addresses leave the stored state untouched, which the bench confirms by reading the state back once the lock is released.

// File: rtl/lut_sat_pkg.sv
package lut_sat_pkg;

  localparam int LUT_IDX_W = 8;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_TBL,
    RD_USR,
    RD_LSR
  } rdSrc_e;

  typedef struct packed {
    logic                 tblWr;
    logic                 usrWr;
    logic                 lsrWr;
    logic                 rdEn;
    rdSrc_e               rdSrc;
    logic [LUT_IDX_W-1:0] offset;
  } hostStrb_t;

endpackage

// File: rtl/lut_sat_ctrl.sv
module lut_sat_ctrl
  import lut_sat_pkg::*;
#(
  parameter int IDX_W      = LUT_IDX_W,
  parameter int WORD_BYTES = 4
) (
  input  logic             runEn,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic [IDX_W:0]   hostAddr,
  output hostStrb_t        strb
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] USR_BASE = (IDX_W+1)'(DEPTH - 2*WORD_BYTES);
  localparam logic [IDX_W:0] LSR_BASE = (IDX_W+1)'(DEPTH - WORD_BYTES);

  logic inTbl, inUsr, inLsr, hostOpen;

  always_comb begin
    hostOpen = !runEn;
    inTbl    = hostAddr[IDX_W];
    inUsr    = !hostAddr[IDX_W] && (hostAddr >= USR_BASE) && (hostAddr < LSR_BASE);
    inLsr    = !hostAddr[IDX_W] && (hostAddr >= LSR_BASE);

    strb        = '0;
    strb.offset = hostAddr[IDX_W-1:0];
    strb.tblWr  = hostOpen && hostWrEn && inTbl;
    strb.usrWr  = hostOpen && hostWrEn && inUsr;
    strb.lsrWr  = hostOpen && hostWrEn && inLsr;
    strb.rdEn   = hostRdEn;
    strb.rdSrc  = RD_ZERO;
    if (hostOpen && hostRdEn) begin
      if (inTbl)      strb.rdSrc = RD_TBL;
      else if (inUsr) strb.rdSrc = RD_USR;
      else if (inLsr) strb.rdSrc = RD_LSR;
    end
  end

endmodule

// File: rtl/lut_sat_dp.sv
module lut_sat_dp
  import lut_sat_pkg::*;
#(
  parameter int IDX_W      = LUT_IDX_W,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  hostStrb_t               strb,
  input  logic [7:0]              hostWrData,
  output logic [7:0]              hostRdData,
  input  logic                    mode32,
  input  logic                    idxValid,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    posOvf,
  input  logic                    negOvf,
  output logic                    outValid,
  output logic [8*WORD_BYTES-1:0] outData
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int OUT_W = 8 * WORD_BYTES;
  localparam int SEL_W = $clog2(WORD_BYTES);

  logic [7:0]       tbl [DEPTH];
  logic [OUT_W-1:0] usrReg, lsrReg;
  logic [OUT_W-1:0] wordView, byteView, usrView, lsrView, nextData;
  logic [IDX_W-SEL_W-1:0] wordIdx;
  logic [SEL_W-1:0] laneSel;

  assign laneSel = strb.offset[SEL_W-1:0];
  assign wordIdx = idx[IDX_W-1:SEL_W];

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (strb.tblWr) begin
      tbl[strb.offset] <= hostWrData;
    end
  end

  // saturation words, one byte lane per generate slice
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        usrReg[8*b +: 8] <= '0;
        lsrReg[8*b +: 8] <= '0;
      end else begin
        if (strb.usrWr && laneSel == SEL_W'(b)) usrReg[8*b +: 8] <= hostWrData;
        if (strb.lsrWr && laneSel == SEL_W'(b)) lsrReg[8*b +: 8] <= hostWrData;
      end
    end
    assign wordView[8*b +: 8] = tbl[{wordIdx, SEL_W'(b)}];
  end

  assign byteView = {{(OUT_W-8){1'b0}}, tbl[idx]};
  assign usrView  = mode32 ? usrReg : {{(OUT_W-8){1'b0}}, usrReg[7:0]};
  assign lsrView  = mode32 ? lsrReg : {{(OUT_W-8){1'b0}}, lsrReg[7:0]};

  always_comb begin
    if (posOvf)      nextData = usrView;
    else if (negOvf) nextData = lsrView;
    else if (mode32) nextData = wordView;
    else             nextData = byteView;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= idxValid;
      if (idxValid) outData <= nextData;
    end
  end

  // host read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSrc)
        RD_TBL:  hostRdData <= tbl[strb.offset];
        RD_USR:  hostRdData <= usrReg[8*laneSel +: 8];
        RD_LSR:  hostRdData <= lsrReg[8*laneSel +: 8];
        default: hostRdData <= '0;
      endcase
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == 1'b0 || outValid == 1'b1)
    else $error("valid unknown");
  // R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |=> outValid);
  // R4
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idxValid |=> !outValid);
  // R4
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && !mode32) |=> (outData[OUT_W-1:8] == '0));
  // R6 R8
  pos_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && posOvf && mode32) |=> (outData == $past(usrReg)));
  // R7
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && negOvf && !posOvf && mode32) |=> (outData == $past(lsrReg)));

endmodule

// File: rtl/lut_sat_stage.sv
module lut_sat_stage
  import lut_sat_pkg::*;
#(
  parameter int IDX_W      = LUT_IDX_W,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runEn,
  input  logic                    mode32,
  input  logic                    idxValid,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    posOvf,
  input  logic                    negOvf,
  input  logic [IDX_W:0]          hostAddr,
  input  logic                    hostWrEn,
  input  logic                    hostRdEn,
  input  logic [7:0]              hostWrData,
  output logic [7:0]              hostRdData,
  output logic                    outValid,
  output logic [8*WORD_BYTES-1:0] outData
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] MAP_LO = (IDX_W+1)'(DEPTH - 2*WORD_BYTES);

  hostStrb_t strb;

  lut_sat_ctrl #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .runEn    (runEn),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .strb     (strb)
  );

  lut_sat_dp #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .mode32     (mode32),
    .idxValid   (idxValid),
    .idx        (idx),
    .posOvf     (posOvf),
    .negOvf     (negOvf),
    .outValid   (outValid),
    .outData    (outData)
  );

  // R10
  run_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && runEn) |=> (hostRdData == '0));
  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostAddr[IDX_W] && hostAddr < MAP_LO) |=> (hostRdData == '0));

endmodule

// File: tb/sim_lut_sat_stage.sv
module sim_lut_sat_stage;

  logic        clk = 1'b0;
  logic        rstN;
  logic        runEn, mode32, idxValid, posOvf, negOvf;
  logic [7:0]  idx;
  logic [8:0]  hostAddr;
  logic        hostWrEn, hostRdEn;
  logic [7:0]  hostWrData;
  logic [7:0]  hostRdData;
  logic        outValid;
  logic [31:0] outData;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [31:0] USR_VAL = 32'hC3A5_1E7F;
  localparam logic [31:0] LSR_VAL = 32'h0481_9B26;

  // {mode32, posOvf, negOvf, idx}
  localparam int NVEC = 12;
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'hFF},
    {1'b0, 1'b0, 1'b0, 8'h37},
    {1'b1, 1'b0, 1'b0, 8'h13},
    {1'b1, 1'b0, 1'b0, 8'hFE},
    {1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h44},
    {1'b1, 1'b1, 1'b0, 8'h44},
    {1'b0, 1'b0, 1'b1, 8'h90},
    {1'b1, 1'b0, 1'b1, 8'h90},
    {1'b0, 1'b1, 1'b1, 8'h21},
    {1'b1, 1'b1, 1'b1, 8'h21}
  };

  lut_sat_stage u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .mode32(mode32),
    .idxValid(idxValid), .idx(idx), .posOvf(posOvf), .negOvf(negOvf),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .outValid(outValid), .outData(outData)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] model(logic m32, logic pos, logic neg, logic [7:0] ix);
    int w;
    w = int'(ix) / 4;
    if (pos)      return m32 ? USR_VAL : {24'h0, USR_VAL[7:0]};
    else if (neg) return m32 ? LSR_VAL : {24'h0, LSR_VAL[7:0]};
    else if (m32) return {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    else          return {24'h0, pat(int'(ix))};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [8:0] a, logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [8:0] a, output logic [7:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk);
    d = hostRdData;
    hostRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; runEn = 1'b0; mode32 = 1'b0; idxValid = 1'b0; idx = '0;
    posOvf = 1'b0; negOvf = 1'b0; hostAddr = '0; hostWrEn = 1'b0;
    hostRdEn = 1'b0; hostWrData = '0;
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", {31'h0, outValid}, 32'h0);
    chk("R1 outData in reset", outData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", {31'h0, outValid}, 32'h0);
    chk("R1 outData after reset", outData, 32'h0);
    chk("R1 hostRdData after reset", {24'h0, hostRdData}, 32'h0);

    // load table and saturation words (R2, R3)
    for (int n = 0; n < 256; n++) hostWrite(9'h100 + 9'(n), pat(n));
    for (int b = 0; b < 4; b++) hostWrite(9'h0F8 + 9'(b), USR_VAL[8*b +: 8]);
    for (int b = 0; b < 4; b++) hostWrite(9'h0FC + 9'(b), LSR_VAL[8*b +: 8]);

    hostRead(9'h100, rd); chk("R2 table read 0x100", {24'h0, rd}, {24'h0, pat(0)});
    hostRead(9'h1FF, rd); chk("R2 table read 0x1FF", {24'h0, rd}, {24'h0, pat(255)});
    hostRead(9'h15A, rd); chk("R2 table read 0x15A", {24'h0, rd}, {24'h0, pat(8'h5A)});
    for (int b = 0; b < 4; b++) begin
      hostRead(9'h0F8 + 9'(b), rd); chk("R3 upper sat byte", {24'h0, rd}, {24'h0, USR_VAL[8*b +: 8]});
      hostRead(9'h0FC + 9'(b), rd); chk("R3 lower sat byte", {24'h0, rd}, {24'h0, LSR_VAL[8*b +: 8]});
    end

    // datapath vectors
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [31:0] exp;
      {mode32, posOvf, negOvf, idx} = VEC[v];
      idxValid = 1'b1;
      exp = model(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
      if (VEC[v][9] && VEC[v][8]) tag = "R8 both flags";
      else if (VEC[v][9])         tag = "R6 upper sat";
      else if (VEC[v][8])         tag = "R7 lower sat";
      else if (VEC[v][10])        tag = "R5 word view";
      else                        tag = "R4 byte view";
      @(negedge clk);
      chk(tag, outData, exp);
      chk("R4 outValid high", {31'h0, outValid}, 32'h1);
    end
    idxValid = 1'b0; posOvf = 1'b0; negOvf = 1'b0;
    @(negedge clk);
    chk("R4 outValid low", {31'h0, outValid}, 32'h0);

    // lockout while running (R9, R10)
    runEn = 1'b1;
    hostWrite(9'h110, 8'hEE);
    hostWrite(9'h0F8, 8'h00);
    hostWrite(9'h0FF, 8'h00);
    hostRead(9'h110, rd); chk("R10 table read while running", {24'h0, rd}, 32'h0);
    hostRead(9'h0F9, rd); chk("R10 sat read while running", {24'h0, rd}, 32'h0);
    mode32 = 1'b1; idx = 8'h10; idxValid = 1'b1;
    @(negedge clk);
    chk("R9 datapath word while running", outData, model(1'b1, 1'b0, 1'b0, 8'h10));
    idxValid = 1'b0;
    runEn = 1'b0;
    hostRead(9'h110, rd); chk("R9 table kept", {24'h0, rd}, {24'h0, pat(8'h10)});
    hostRead(9'h0F8, rd); chk("R9 upper sat kept", {24'h0, rd}, {24'h0, USR_VAL[7:0]});
    hostRead(9'h0FF, rd); chk("R9 lower sat kept", {24'h0, rd}, {24'h0, LSR_VAL[31:24]});

    // unmapped addresses (R11)
    hostWrite(9'h050, 8'hAB);
    hostWrite(9'h0F7, 8'hCD);
    hostRead(9'h050, rd); chk("R11 unmapped read 0x050", {24'h0, rd}, 32'h0);
    hostRead(9'h0F7, rd); chk("R11 unmapped read 0x0F7", {24'h0, rd}, 32'h0);
    hostRead(9'h150, rd); chk("R11 table 0x50 untouched", {24'h0, rd}, {24'h0, pat(8'h50)});
    hostRead(9'h1F7, rd); chk("R11 table 0xF7 untouched", {24'h0, rd}, {24'h0, pat(8'hF7)});
    mode32 = 1'b1; posOvf = 1'b1; idxValid = 1'b1;
    @(negedge clk);
    chk("R11 upper sat untouched", outData, USR_VAL);
    posOvf = 1'b0; negOvf = 1'b1;
    @(negedge clk);
    chk("R11 lower sat untouched", outData, LSR_VAL);
    idxValid = 1'b0; negOvf = 1'b0;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule